// File: doc/BRIEF.md
# Bus Configuration Address Translator

This block sits in front of a bridge to an external parallel bus. It takes one configuration-space request at a time. A request carries a bus number, device number, function number, register offset, access size, direction and write data. The block turns the request into two things: a value for the bridge's window-control register and a physical word address inside the configuration window. It then performs the word access on a downstream single-word memory port.

Bus 0 is reached with a one-hot device select. The select bit is `1 << (device + 16)`. The part of that bit which falls inside the window mask is moved into the window-control value, and the rest is folded into the address. Every other bus uses a packed forwarding format with a fixed window code.

Reads of one or two bytes are served by shifting the fetched word to the addressed lane. Writes of one or two bytes are built as a read followed by a merged write. Invalid targets, invalid sizes and downstream bus faults are reported on a single error bit that travels with the response.

Top module: `cfg_xlate`

## Requirements
- R1: For bus 0 the memory address is `CFG_BASE | (S & ~WIN_MASK) | func<<8 | (offset & ~3)`, where `S = 1 << (dev+16)`, with defaults `CFG_BASE = 0x0C000000` and `WIN_MASK = 0xFC000000`.
- R2: For bus 0, exactly one `win_we` pulse precedes the first memory access, carrying `win_val = 0x00000002 | (S & WIN_MASK)`.
- R3: For any bus other than 0, `win_val = 0x00000003` and the memory address is `CFG_BASE | bus<<16 | dev<<11 | func<<8 | (offset & ~3)`. Device numbers of 16 and above are allowed here.
- R4: On bus 0, a device number of 16 or more is rejected. The response has `rsp_err = 1` and `rsp_rdata = 0`, there is no window write and no memory access, and `rsp_valid` comes one cycle after acceptance.
- R5: While `card_mode` is 1, any device number other than 0 is rejected on every bus, in the same way as R4.
- R6: An access size (in bytes, on `req_size`) other than 1, 2 or 4 is rejected in the same way as R4.
- R7: A read returns the fetched word shifted right by `8*(offset & 3)`, then zero-extended from its low 8 bits (size 1), its low 16 bits (size 2), or kept whole (size 4).
- R8: A 1- or 2-byte write reads the word, replaces the 8- or 16-bit lane at bit `8*(offset & 3)` with the low bits of `req_wdata`, and writes the word back to the same address.
- R9: A 4-byte write performs a single memory write of `req_wdata` and no read.
- R10: A downstream error gives `rsp_err = 1`. A read with an error returns `rsp_rdata = 0xFFFFFFFF`. A read error during a partial write suppresses the write.
- R11: After reset, `req_ready = 1` and `rsp_valid`, `mem_valid` and `win_we` are 0. `req_ready` stays low from acceptance until the response cycle has passed.
- R12: `rsp_valid` is a single-cycle pulse. `rsp_err` and `rsp_rdata` are 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2, 4 valid) |
| req_wdata | input | 32 | Write data, right-aligned |
| card_mode | input | 1 | Single-slot card mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Error flag, valid with rsp_valid |
| rsp_rdata | output | 32 | Read result |
| win_we | output | 1 | Window-control register write strobe |
| win_val | output | 32 | Window-control register value |
| mem_valid | output | 1 | Memory access request, held until mem_ready |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word address of access |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_err | input | 1 | Memory error, valid with mem_ready |

## Verification
The response is due a fixed number of cycles after acceptance, counting cycles with a zero-wait memory:
- one cycle for a rejected request;
- three cycles for a read or a full write (window cycle, access cycle, response cycle);
- four cycles for a partial write, which needs a second access.

Each memory wait state adds one cycle. The bench drives every request and samples every output on the falling edge, counting falling edges from acceptance to the response. It compares that count with the expected figure, which confirms each result appears in the cycle it is due. The memory model asserts ready on a falling edge and logs the address, data and direction of each access and window write in that same cycle. Access counts and addresses are therefore checked against the requirement formulas once the response has arrived.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SIZE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN,
        ST_RD,
        ST_WR,
        ST_RSP
    } fsm_e;

    typedef struct packed {
        fsm_e              fsm;
        logic              write;
        logic [SIZE_W-1:0] size;
        logic [1:0]        lane;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] win;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] rdata;
        logic              err;
    } xl_state_t;

endpackage

// File: rtl/cfg_xlate_decode.sv
module cfg_xlate_decode #(
    parameter int          BUS_W    = 8,
    parameter int          DEV_W    = 5,
    parameter int          FUNC_W   = 3,
    parameter int          OFF_W    = 8,
    parameter int          SLOT_MAX = 16,
    parameter int          SEL_BASE = 16,
    parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
    parameter logic [31:0] WIN_MASK = 32'hFC00_0000,
    parameter logic [31:0] CODE_T0  = 32'h0000_0002,
    parameter logic [31:0] CODE_T1  = 32'h0000_0003
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  off,
    input  logic [2:0]        size,
    input  logic              card_mode,
    output logic [31:0]       addr,
    output logic [31:0]       win,
    output logic              bad
);
    localparam logic [31:0] SLOT_LIM   = 32'(SLOT_MAX);
    localparam logic [31:0] SHIFT_BASE = 32'(SEL_BASE);
    localparam int          BUS_SH     = 16;
    localparam int          DEV_SH     = 11;
    localparam int          FUNC_SH    = 8;

    logic [31:0] dev_w;
    logic [31:0] sel;
    logic [31:0] off_al;
    logic [31:0] fn_part;
    logic        size_ok;
    logic        range_bad;

    always_comb begin
        dev_w   = 32'(dev);
        sel     = '0;
        if (dev_w < SLOT_LIM) begin
            sel = 32'd1 << (dev_w + SHIFT_BASE);
        end
        off_al  = 32'(off) & ~32'd3;
        fn_part = 32'(func) << FUNC_SH;
        size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        if (bus == '0) begin
            addr      = CFG_BASE | (sel & ~WIN_MASK) | fn_part | off_al;
            win       = CODE_T0 | (sel & WIN_MASK);
            range_bad = (dev_w >= SLOT_LIM);
        end else begin
            addr      = CFG_BASE | (32'(bus) << BUS_SH) | (dev_w << DEV_SH)
                      | fn_part | off_al;
            win       = CODE_T1;
            range_bad = 1'b0;
        end
        bad = !size_ok || range_bad || (card_mode && (dev != '0));
    end

endmodule

// File: rtl/cfg_xlate_lane.sv
module cfg_xlate_lane (
    input  logic [31:0] word,
    input  logic [31:0] wdata,
    input  logic [1:0]  lane,
    input  logic [2:0]  size,
    output logic [31:0] rd_val,
    output logic [31:0] merged
);
    logic [4:0]  sh;
    logic [31:0] shifted;
    logic [31:0] mask;
    logic [31:0] ins;

    always_comb begin
        sh      = {lane, 3'b000};
        shifted = word >> sh;
        case (size)
            3'd1:    rd_val = {24'd0, shifted[7:0]};
            3'd2:    rd_val = {16'd0, shifted[15:0]};
            default: rd_val = shifted;
        endcase
        if (size == 3'd1) begin
            mask = 32'h0000_00FF << sh;
            ins  = {24'd0, wdata[7:0]} << sh;
        end else begin
            mask = 32'h0000_FFFF << sh;
            ins  = {16'd0, wdata[15:0]} << sh;
        end
        merged = (word & ~mask) | ins;
    end

endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int          SLOT_MAX = 16,
    parameter logic [31:0] CFG_BASE = 32'h0C00_0000,
    parameter logic [31:0] WIN_MASK = 32'hFC00_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_func,
    input  logic [7:0]  req_off,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    input  logic        card_mode,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        win_we,
    output logic [31:0] win_val,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err
);
    xl_state_t   st_d, st_q;
    logic [31:0] dec_addr, dec_win;
    logic        dec_bad;
    logic [31:0] lane_rd, lane_merged;

    cfg_xlate_decode #(
        .SLOT_MAX (SLOT_MAX),
        .CFG_BASE (CFG_BASE),
        .WIN_MASK (WIN_MASK)
    ) u_decode (
        .bus       (req_bus),
        .dev       (req_dev),
        .func      (req_func),
        .off       (req_off),
        .size      (req_size),
        .card_mode (card_mode),
        .addr      (dec_addr),
        .win       (dec_win),
        .bad       (dec_bad)
    );

    cfg_xlate_lane u_lane (
        .word   (mem_rdata),
        .wdata  (st_q.wdata),
        .lane   (st_q.lane),
        .size   (st_q.size),
        .rd_val (lane_rd),
        .merged (lane_merged)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.fsm)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.write = req_write;
                    st_d.size  = req_size;
                    st_d.lane  = req_off[1:0];
                    st_d.wdata = req_wdata;
                    st_d.addr  = dec_addr;
                    st_d.win   = dec_win;
                    st_d.word  = req_wdata;
                    st_d.rdata = '0;
                    st_d.err   = dec_bad;
                    st_d.fsm   = dec_bad ? ST_RSP : ST_WIN;
                end
            end
            ST_WIN: begin
                st_d.fsm = (st_q.write && st_q.size == 3'd4) ? ST_WR : ST_RD;
            end
            ST_RD: begin
                if (mem_ready) begin
                    if (mem_err) begin
                        st_d.err   = 1'b1;
                        st_d.rdata = st_q.write ? 32'd0 : 32'hFFFF_FFFF;
                        st_d.fsm   = ST_RSP;
                    end else if (st_q.write) begin
                        st_d.word = lane_merged;
                        st_d.fsm  = ST_WR;
                    end else begin
                        st_d.rdata = lane_rd;
                        st_d.fsm   = ST_RSP;
                    end
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    st_d.err = mem_err;
                    st_d.fsm = ST_RSP;
                end
            end
            default: begin
                st_d.err   = 1'b0;
                st_d.rdata = '0;
                st_d.fsm   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fsm <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.fsm == ST_IDLE);
    assign rsp_valid = (st_q.fsm == ST_RSP);
    assign rsp_err   = st_q.err;
    assign rsp_rdata = st_q.rdata;
    assign win_we    = (st_q.fsm == ST_WIN);
    assign win_val   = st_q.win;
    assign mem_valid = (st_q.fsm == ST_RD) || (st_q.fsm == ST_WR);
    assign mem_write = (st_q.fsm == ST_WR);
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.word;

    assert_win_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(win_we));

    assert_dev_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_bus == 8'd0 && req_dev >= 5'd16)
        |=> (rsp_valid && rsp_err));

    assert_card_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && card_mode && req_dev != 5'd0)
        |=> (rsp_valid && rsp_err));

    assert_size_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size != 3'd1 && req_size != 3'd2
         && req_size != 3'd4) |=> (rsp_valid && rsp_err));

    assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !rsp_err && rsp_rdata == 32'd0));

endmodule

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        card_mode = 1'b0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        win_we;
    logic [31:0] win_val;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    int checks = 0;
    int failures = 0;

    int          wait_cfg = 0;
    logic        err_cfg = 1'b0;
    logic [31:0] model_word = '0;
    int          wcnt = 0;
    int          n_win, n_rd, n_wr;
    logic [31:0] last_win, rd_addr, wr_addr, wr_data;

    logic [31:0] got_rdata;
    logic        got_err;
    int          got_lat;

    always #4 clk = ~clk;

    cfg_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .card_mode(card_mode),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .win_we(win_we), .win_val(win_val),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_err(mem_err)
    );

    always @(negedge clk) begin
        mem_ready = 1'b0;
        mem_err   = 1'b0;
        if (win_we) begin
            n_win++;
            last_win = win_val;
        end
        if (mem_valid) begin
            if (wcnt < wait_cfg) begin
                wcnt++;
            end else begin
                wcnt      = 0;
                mem_ready = 1'b1;
                mem_err   = err_cfg;
                mem_rdata = model_word;
                if (mem_write) begin
                    n_wr++;
                    wr_addr = mem_addr;
                    wr_data = mem_wdata;
                    if (!err_cfg) model_word = mem_wdata;
                end else begin
                    n_rd++;
                    rd_addr = mem_addr;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                          input logic [2:0] fn, input logic [7:0] off,
                          input logic [2:0] sz, input logic [31:0] wd);
        @(negedge clk);
        n_win = 0; n_rd = 0; n_wr = 0;
        req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
        req_func = fn; req_off = off; req_size = sz; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_lat = 1;
        chk("R11 ready low while busy", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid) begin
            @(negedge clk);
            got_lat++;
        end
        got_rdata = rsp_rdata;
        got_err   = rsp_err;
        @(negedge clk);
        chk("R12 response single pulse", {30'd0, rsp_valid, rsp_err}, 32'd0);
        chk("R12 rdata cleared after pulse", rsp_rdata, 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R11 reset quiet", {29'd0, rsp_valid, mem_valid, win_we}, 32'd0);
    endtask

    task automatic t_type0();
        model_word = 32'hA1B2_C3D4;
        do_req(1'b0, 8'd0, 5'd3, 3'd2, 8'h0E, 3'd1, 32'd0);
        chk("R1 type0 address dev3", rd_addr, 32'h0C08_020C);
        chk("R2 type0 window low dev", last_win, 32'h0000_0002);
        chk("R2 one window write", n_win, 1);
        chk("R7 byte lane 2", got_rdata, 32'h0000_00B2);
        chk("R7 no error", {31'd0, got_err}, 32'd0);
        chk("R11 read latency", got_lat, 3);
        do_req(1'b0, 8'd0, 5'd12, 3'd0, 8'h40, 3'd4, 32'd0);
        chk("R2 type0 window dev12", last_win, 32'h1000_0002);
        chk("R1 type0 address dev12", rd_addr, 32'h0C00_0040);
        chk("R7 full word", got_rdata, 32'hA1B2_C3D4);
        do_req(1'b0, 8'd0, 5'd15, 3'd7, 8'h00, 3'd4, 32'd0);
        chk("R2 type0 window dev15", last_win, 32'h8000_0002);
        chk("R1 type0 address dev15", rd_addr, 32'h0C00_0700);
    endtask

    task automatic t_type1();
        model_word = 32'hA1B2_C3D4;
        do_req(1'b0, 8'd5, 5'd7, 3'd1, 8'h12, 3'd2, 32'd0);
        chk("R3 type1 address", rd_addr, 32'h0C05_3910);
        chk("R3 type1 window", last_win, 32'h0000_0003);
        chk("R7 half lane 2", got_rdata, 32'h0000_A1B2);
        do_req(1'b0, 8'd3, 5'd20, 3'd0, 8'h04, 3'd4, 32'd0);
        chk("R3 type1 dev20 accepted", {31'd0, got_err}, 32'd0);
        chk("R3 type1 address dev20", rd_addr, 32'h0C03_A004);
    endtask

    task automatic t_lanes();
        model_word = 32'hA1B2_C3D4;
        do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h03, 3'd2, 32'd0);
        chk("R7 half at lane 3", got_rdata, 32'h0000_00A1);
        do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h01, 3'd4, 32'd0);
        chk("R7 word shifted lane 1", got_rdata, 32'h00A1_B2C3);
        do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h00, 3'd1, 32'd0);
        chk("R7 byte lane 0", got_rdata, 32'h0000_00D4);
    endtask

    task automatic t_rmw();
        model_word = 32'h1122_3344;
        do_req(1'b1, 8'd0, 5'd0, 3'd0, 8'h41, 3'd1, 32'hFFFF_FF5A);
        chk("R8 one read", n_rd, 1);
        chk("R8 one write", n_wr, 1);
        chk("R8 byte merge", wr_data, 32'h1122_5A44);
        chk("R8 same address", wr_addr, rd_addr);
        chk("R8 partial write latency", got_lat, 4);
        do_req(1'b1, 8'd0, 5'd0, 3'd0, 8'h42, 3'd2, 32'h0000_BEEF);
        chk("R8 half merge", wr_data, 32'hBEEF_5A44);
    endtask

    task automatic t_full_write();
        model_word = 32'h1234_5678;
        do_req(1'b1, 8'd0, 5'd1, 3'd0, 8'h44, 3'd4, 32'hCAFE_F00D);
        chk("R9 no read", n_rd, 0);
        chk("R9 one write", n_wr, 1);
        chk("R9 data direct", wr_data, 32'hCAFE_F00D);
        chk("R9 latency", got_lat, 3);
    endtask

    task automatic t_reject_dev();
        do_req(1'b0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 32'd0);
        chk("R4 dev16 error", {31'd0, got_err}, 32'd1);
        chk("R4 rdata zero", got_rdata, 32'd0);
        chk("R4 no access", n_win + n_rd + n_wr, 0);
        chk("R4 latency", got_lat, 1);
        do_req(1'b1, 8'd0, 5'd31, 3'd0, 8'h00, 3'd4, 32'd5);
        chk("R4 dev31 error", {31'd0, got_err}, 32'd1);
        chk("R4 dev31 no access", n_win + n_rd + n_wr, 0);
    endtask

    task automatic t_card();
        card_mode = 1'b1;
        do_req(1'b0, 8'd2, 5'd1, 3'd0, 8'h00, 3'd4, 32'd0);
        chk("R5 card dev1 error", {31'd0, got_err}, 32'd1);
        chk("R5 card no access", n_win + n_rd + n_wr, 0);
        do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 32'd0);
        chk("R5 card dev0 accepted", {31'd0, got_err}, 32'd0);
        card_mode = 1'b0;
    endtask

    task automatic t_size();
        for (int k = 0; k < 4; k++) begin
            logic [2:0] sz;
            sz = (k == 0) ? 3'd0 : (k == 1) ? 3'd3 : (k == 2) ? 3'd5 : 3'd7;
            do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h00, sz, 32'd0);
            chk("R6 bad size error", {31'd0, got_err}, 32'd1);
            chk("R6 bad size no access", n_win + n_rd + n_wr, 0);
        end
    endtask

    task automatic t_buserr();
        err_cfg = 1'b1;
        do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h01, 3'd1, 32'd0);
        chk("R10 read error flag", {31'd0, got_err}, 32'd1);
        chk("R10 read all ones", got_rdata, 32'hFFFF_FFFF);
        do_req(1'b1, 8'd0, 5'd0, 3'd0, 8'h01, 3'd1, 32'd7);
        chk("R10 partial write error", {31'd0, got_err}, 32'd1);
        chk("R10 partial write suppressed", n_wr, 0);
        do_req(1'b1, 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 32'd7);
        chk("R10 full write error", {31'd0, got_err}, 32'd1);
        err_cfg = 1'b0;
    endtask

    task automatic t_wait();
        wait_cfg = 3;
        model_word = 32'h0BAD_F00D;
        do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 32'd0);
        chk("R11 stalled latency", got_lat, 6);
        chk("R7 stalled read data", got_rdata, 32'h0BAD_F00D);
        wait_cfg = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_type0();
        t_type1();
        t_lanes();
        t_rmw();
        t_full_write();
        t_reject_dev();
        t_card();
        t_size();
        t_buserr();
        t_wait();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule